// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This peripheral watches one non-maskable interrupt line that arrives from outside the clock domain. It turns activity on that line into one request toward a parent interrupt controller. The input first passes through a flop synchronizer. A detector then matches the synchronized level against one of four trigger conditions: low level, falling edge, high level or rising edge. A match latches into a pending bit, and the pending bit gated by an enable bit drives the request output.

Software reaches the block through a simple single-cycle register bus with three 32-bit registers. The control register selects the trigger condition. The status register holds the pending flag, and writing a one to it acknowledges the event. The mask register holds the enable bit. The mask register's offset is a parameter, which lets one netlist serve both register-map variants (mask at 0x08 or at 0x34). Read data is combinational from the addressed register.

Top module: `nmi_trigger_ctrl`

## Requirements
- R1: After reset the control register reads 0 (low-level mode), the status and mask registers read 0 and `irq_out` is low.
- R2: Control bits [1:0] select the trigger: code 0 low level, 1 falling edge, 2 high level, 3 rising edge. Writes store only these two bits, and control bits [31:2] read 0.
- R3: Control sits at offset 0x00, status at 0x04 and mask at `EN_OFFSET` (0x08 or 0x34). Any other offset reads 0 and ignores writes. Unused bits of status and mask read 0.
- R4: In an edge mode the pending bit (status bit 0) sets on the selected transition of the synchronized input only. It stays set after the input returns, until it is acknowledged.
- R5: In a level mode the pending bit sets while the synchronized input is at the active level. An acknowledge given while the level is still active leaves it set. An acknowledge given after the level went inactive clears it.
- R6: Writing 1 to status bit 0 clears the pending bit. Writing 0 there changes nothing.
- R7: `irq_out` is high exactly when the pending bit and mask bit 0 are both 1. The pending bit still latches while the mask bit is 0.
- R8: When an acknowledge and a new trigger event fall in the same cycle, the pending bit stays set.
- R9: Changing the mode never sets the pending bit through edge detection. A transition seen in the first cycle after a mode-changing control write is dropped. Entering an edge mode while the input is static sets nothing.
- R10: An input change sampled at one clock edge shows on the pending bit, and on `irq_out` when enabled, after `SYNC_STAGES`+1 rising edges counted from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Asynchronous NMI line |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | 1 | Request toward the parent controller |

## Verification
The bench builds the block with `EN_OFFSET` = 0x34 and two synchronizer stages. With the mask at 0x34, offset 0x08 becomes an unmapped hole, so the bench can show that a write there leaves the mask untouched. The two-stage depth fixes a three-edge input-to-pending latency, and the bench times two cases against it: an acknowledge that lands in the same cycle as a fresh edge, and a mode-changing write that lands in the same cycle as an edge.

// File: rtl/nmi_trig_pkg.sv
package nmi_trig_pkg;

   localparam int unsigned REG_W = 32;

   // Code order is decoded by the detector: bit 1 is the active level,
   // bit 0 selects edge detection.
   typedef enum logic [1:0] {
      TRIG_LVL_LO    = 2'd0,
      TRIG_EDGE_FALL = 2'd1,
      TRIG_LVL_HI    = 2'd2,
      TRIG_EDGE_RISE = 2'd3
   } trig_mode_e;

   function automatic logic mode_is_edge(trig_mode_e m);
      return m[0];
   endfunction

   function automatic logic mode_active_lvl(trig_mode_e m);
      return m[1];
   endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
   import nmi_trig_pkg::*;
#(
   parameter logic RST_LVL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  trig_mode_e mode,
   output logic       evt
);

   logic       prev_q;
   trig_mode_e seen_q;
   logic       mode_settled;
   logic       at_active;
   logic       edge_hit;

   assign mode_settled = (mode == seen_q);
   assign at_active    = (lvl == mode_active_lvl(mode));
   assign edge_hit     = mode_settled && at_active && (prev_q != lvl);
   assign evt          = mode_is_edge(mode) ? edge_hit : at_active;

   // Edge history is reloaded from the current sample each cycle; a mode
   // change additionally blanks edge detection for one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_LVL;
         seen_q <= TRIG_LVL_LO;
      end else begin
         prev_q <= lvl;
         seen_q <= mode;
      end
   end

endmodule

// File: rtl/nmi_regs.sv
module nmi_regs
   import nmi_trig_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CTRL_OFF  = 0,
   parameter int unsigned PEND_OFF  = 4,
   parameter int unsigned EN_OFF    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              evt,
   output trig_mode_e        mode,
   output logic              pend,
   output logic              en,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFF);
   localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFF);

   trig_mode_e mode_q;
   logic       pend_q;
   logic       en_q;
   logic       hit_ctrl, hit_pend, hit_en;
   logic       wr_ctrl, wr_en, ack;

   assign hit_ctrl = (bus_addr == CTRL_A);
   assign hit_pend = (bus_addr == PEND_A);
   assign hit_en   = (bus_addr == EN_A);

   assign wr_ctrl = bus_sel && bus_wr && hit_ctrl;
   assign wr_en   = bus_sel && bus_wr && hit_en;
   assign ack     = bus_sel && bus_wr && hit_pend && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= TRIG_LVL_LO;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_ctrl) mode_q <= trig_mode_e'(bus_wdata[1:0]);
         if (wr_en)   en_q   <= bus_wdata[0];
         // a fresh event outranks a same-cycle acknowledge
         pend_q <= evt | (pend_q & ~ack);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl)      bus_rdata[1:0] = mode_q;
      else if (hit_pend) bus_rdata[0]   = pend_q;
      else if (hit_en)   bus_rdata[0]   = en_q;
   end

   assign mode = mode_q;
   assign pend = pend_q;
   assign en   = en_q;
   assign irq  = pend_q & en_q;

endmodule

// File: rtl/nmi_trigger_ctrl.sv
module nmi_trigger_ctrl
   import nmi_trig_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned EN_OFFSET   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_out
);

   localparam int unsigned CTRL_OFFSET = 0;
   localparam int unsigned PEND_OFFSET = 4;
   // inactive level of the reset mode, so reset raises no event
   localparam logic        IDLE_LVL    = 1'b1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if ((EN_OFFSET % 4) != 0 || EN_OFFSET == CTRL_OFFSET || EN_OFFSET == PEND_OFFSET ||
       EN_OFFSET >= (1 << ADDR_W)) begin : g_bad_off
      $error("EN_OFFSET must be word aligned, distinct and inside the address space");
   end

   logic       lvl_sync;
   logic       evt_w;
   logic       pend_w;
   logic       en_w;
   trig_mode_e mode_w;

   nmi_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IDLE_LVL)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (nmi_in),
      .q_sync  (lvl_sync)
   );

   nmi_detect #(
      .RST_LVL (IDLE_LVL)
   ) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync),
      .mode  (mode_w),
      .evt   (evt_w)
   );

   nmi_regs #(
      .ADDR_W   (ADDR_W),
      .CTRL_OFF (CTRL_OFFSET),
      .PEND_OFF (PEND_OFFSET),
      .EN_OFF   (EN_OFFSET)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .evt       (evt_w),
      .mode      (mode_w),
      .pend      (pend_w),
      .en        (en_w),
      .irq       (irq_out)
   );

endmodule

// File: rtl/nmi_trigger_ctrl_chk.sv
module nmi_trigger_ctrl_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned EN_OFFSET = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              evt,
   input logic              pend,
   input logic              en
);

   logic wr_any, ack1, ack0;
   assign wr_any = bus_sel && bus_wr;
   assign ack1   = wr_any && (bus_addr == ADDR_W'(4)) && bus_wdata[0];
   assign ack0   = wr_any && (bus_addr == ADDR_W'(4)) && !bus_wdata[0];

   // R4
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !ack1 |=> pend);

   // R8
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> pend);

   // R6
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack1 && !evt |=> !pend);

   // R6
   ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack0 && !evt |=> $stable(pend));

   // R4
   no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend && !evt |=> !pend);

   // R3
   en_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any && (bus_addr != ADDR_W'(EN_OFFSET)) |=> $stable(en));

endmodule

bind nmi_trigger_ctrl nmi_trigger_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .EN_OFFSET (EN_OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .evt       (evt_w),
   .pend      (pend_w),
   .en        (en_w)
);

// File: tb/nmi_trigger_ctrl_bench.sv
module nmi_trigger_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 8;
   localparam int EN_OFF     = 'h34;
   localparam int STAGES     = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_in = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_out;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nmi_trigger_ctrl #(
      .ADDR_W      (AW),
      .EN_OFFSET   (EN_OFF),
      .SYNC_STAGES (STAGES)
   ) u_nmi_trigger_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_in    (nmi_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int   m_mode, m_seen, m_prev, m_pend, m_en;
   logic sq[$];

   always @(posedge clk or negedge rst_n) begin
      int s, act, ev, ack;
      if (!rst_n) begin
         m_mode = 0; m_seen = 0; m_prev = 1; m_pend = 0; m_en = 0;
         sq.delete();
         for (int i = 0; i < STAGES; i++) sq.push_back(1'b1);
      end else begin
         s   = int'(sq[0]);
         act = (s == m_mode / 2) ? 1 : 0;
         if (m_mode % 2 == 1) ev = (act == 1 && s != m_prev && m_mode == m_seen) ? 1 : 0;
         else                 ev = act;
         ack = (bus_sel && bus_wr && bus_addr == AW'(4) && bus_wdata[0]) ? 1 : 0;
         m_seen = m_mode;
         m_prev = s;
         if (ev == 1)       m_pend = 1;
         else if (ack == 1) m_pend = 0;
         if (bus_sel && bus_wr && bus_addr == AW'(0))      m_mode = int'(bus_wdata[1:0]);
         if (bus_sel && bus_wr && bus_addr == AW'(EN_OFF)) m_en = int'(bus_wdata[0]);
         void'(sq.pop_front());
         sq.push_back(nmi_in);
      end
   end

   // R7: request compared against the model on every clock
   always @(negedge clk) begin
      if (rst_n && !finished)
         check(irq_out == (m_pend == 1 && m_en == 1), "R7 irq_out vs model",
               irq_out, (m_pend == 1 && m_en == 1));
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int addr, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr);
      #1;
      check(bus_rdata == exp, tag, bus_rdata, exp);
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_in(input logic v);
      @(negedge clk);
      nmi_in = v;
   endtask

   // ---------------- directed sequence ----------------
   initial begin
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      rd(0, 0, "R1 ctrl reset");
      rd(4, 0, "R1 pend reset");
      rd(EN_OFF, 0, "R1 en reset");
      check(irq_out == 1'b0, "R1 irq reset", irq_out, 0);

      // R2 only two mode bits stored
      wr(0, 32'hFFFF_FFF1);
      rd(0, 32'h1, "R2 ctrl upper bits read zero");
      wr(0, 32'h0);
      rd(0, 32'h0, "R2 ctrl back to low level");

      // R3 map: 0x08 is a hole in this variant
      wr('h08, 32'h1);
      rd('h08, 0, "R3 hole reads zero");
      rd(EN_OFF, 0, "R3 hole write left mask alone");
      rd('h40, 0, "R3 other hole reads zero");
      wr(EN_OFF, 32'hFFFF_FFFF);
      rd(EN_OFF, 32'h1, "R3 mask unused bits zero");

      // R5 low-level mode
      set_in(1'b0); idle(4);
      rd(4, 1, "R5 low level sets pending");
      check(irq_out == 1'b1, "R7 irq when enabled", irq_out, 1);
      wr(4, 1);
      rd(4, 1, "R5 ack while active re-sets");
      set_in(1'b1); idle(4);
      wr(4, 1);
      rd(4, 0, "R5 ack after release clears");

      // R4/R9 rising edge mode
      wr(0, 3); idle(4);
      rd(4, 0, "R9 entering rise mode while high");
      set_in(1'b0); idle(4);
      rd(4, 0, "R4 falling ignored in rise mode");
      set_in(1'b1); idle(4);
      rd(4, 1, "R4 rising edge latches");
      set_in(1'b0); idle(4);
      rd(4, 1, "R4 holds after input returns");
      wr(4, 0);
      rd(4, 1, "R6 writing zero has no effect");
      wr(4, 1);
      rd(4, 0, "R6 writing one clears");

      // R4 falling edge mode
      wr(0, 1);
      set_in(1'b1); idle(4);
      rd(4, 0, "R4 rising ignored in fall mode");
      set_in(1'b0); idle(4);
      rd(4, 1, "R4 falling edge latches");
      wr(4, 1);

      // R7 masked latching
      wr(EN_OFF, 0);
      set_in(1'b1); idle(4);
      set_in(1'b0); idle(4);
      rd(4, 1, "R7 pending latches while masked");
      check(irq_out == 1'b0, "R7 masked irq low", irq_out, 0);
      wr(EN_OFF, 1);
      check(irq_out == 1'b1, "R7 unmask raises irq", irq_out, 1);
      wr(4, 1);

      // R5 high-level mode
      wr(0, 2); idle(4);
      rd(4, 0, "R5 high mode idle low");
      set_in(1'b1); idle(4);
      rd(4, 1, "R5 high level sets pending");
      wr(4, 1);
      rd(4, 1, "R5 high level re-sets after ack");
      set_in(1'b0); idle(4);
      wr(4, 1);
      rd(4, 0, "R5 high level cleared after release");

      // R10 latency, rising mode, enabled
      wr(0, 3); idle(4);
      wr(4, 1);
      @(negedge clk); nmi_in = 1'b1;
      @(negedge clk);
      check(irq_out == 1'b0, "R10 after 1 edge", irq_out, 0);
      @(negedge clk);
      check(irq_out == 1'b0, "R10 after 2 edges", irq_out, 0);
      @(negedge clk);
      check(irq_out == 1'b1, "R10 after 3 edges", irq_out, 1);

      // R8 ack collides with a new rising edge
      set_in(1'b0); idle(4);
      wr(4, 1);
      rd(4, 0, "R8 setup clear");
      @(negedge clk); nmi_in = 1'b1;
      @(negedge clk);
      wr(4, 1);
      rd(4, 1, "R8 event wins over ack");
      wr(4, 1);

      // R9 mode-changing write coincides with an edge
      wr(0, 1);
      set_in(1'b0); idle(4);
      wr(4, 1);
      @(negedge clk); nmi_in = 1'b1;
      wr(0, 3);
      idle(4);
      rd(4, 0, "R9 edge dropped on mode change");

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule